// File: doc/BRIEF.md
# Two-Wire Master Command Register

This block is the write-only command register that sits in front of a two-wire (I2C/SMBus) master engine. Software writes a command word at the register's offset. Each write is decoded into one-shot strobes. Two of the strobe pairs set and clear persistent mode flags: one turns the master on, the other selects SMBus mode. Separate set and clear bits mean a single write can change one flag without any read-modify-write. A zero written to any command bit changes nothing, and reserved bits are ignored.

The remaining commands control the transfer engine. A stop command is latched as pending. The block raises the stop request towards the shifter only while the shifter reports idle. The pending state is released when the shifter confirms that the STOP condition went out. From that point the engine is held suspended, and no queued transfer starts again until software writes the master-on bit. A soft-reset command produces a one-cycle halt pulse that stops the engine at once. The command is honoured only while the master is already on. The pulse clears the stop and suspend state and leaves the mode flags as they are.

A read of the register returns zero.

Top module: `i2cm_cmd_reg`

## Requirements
- R1: After reset, master_on, smbus_on, stop_req, halt and xfer_hold are all 0.
- R2: In a write to the command offset, bit 0 set makes master_on 1 and bit 1 set makes master_on 0, visible from the clock after the write. If both bits are set, master_on becomes 0.
- R3: In a write to the command offset, bit 4 set makes smbus_on 1 and bit 5 set makes smbus_on 0, visible from the clock after the write. If both bits are set, smbus_on becomes 0.
- R4: Command bits written as zero, reserved bits (every bit other than 0, 1, 4, 5, 7 and 8), and writes to any other offset leave every output unchanged.
- R5: A write with bit 7 set while master_on is already 1 makes halt 1 for exactly the one cycle after the write. If master_on is 0, including when the same write sets bit 0, no pulse is produced.
- R6: A halt pulse clears any pending stop and clears xfer_hold. It leaves master_on and smbus_on unchanged.
- R7: A write with bit 8 set while xfer_active is 1 makes a stop pending. When xfer_active is 0 the stop bit is ignored.
- R8: stop_req is 1 exactly while a stop is pending and shf_idle is 1. While the shifter is busy, the pending stop waits.
- R9: One cycle of stop_done while a stop is pending clears the pending stop. A second stop write made while one is already pending is absorbed, so a single stop_done clears both.
- R10: Completion of a pending stop sets xfer_hold to 1. xfer_hold stays 1 until a command write with bit 0 set clears it.
- R11: bus_rdata is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, always zero |
| shf_idle | input | 1 | Shifter has no byte in flight |
| xfer_active | input | 1 | A transfer is in progress |
| stop_done | input | 1 | Shifter confirms that the STOP condition has been sent |
| master_on | output | 1 | Persistent master-enabled flag |
| smbus_on | output | 1 | Persistent SMBus-mode flag |
| stop_req | output | 1 | Request to the shifter to drive STOP now |
| halt | output | 1 | One-cycle soft-reset pulse to the transfer engine |
| xfer_hold | output | 1 | Queued transfers are suspended after a commanded stop |

## Verification
The assertions assume that stop_done is raised only in response to stop_req, and only for a single cycle. They also assume that the bus write strobe is synchronous and lasts one cycle per command. The stimulus drives every input on the falling edge. It raises stop_done only while stop_req is observed high and drops it after one cycle. It never overlaps a stop_done cycle with a command write, so the relative priority of those two events is never exercised.

// File: rtl/i2cm_cmd_pkg.sv
package i2cm_cmd_pkg;

    localparam int unsigned BIT_MON   = 0;
    localparam int unsigned BIT_MOFF  = 1;
    localparam int unsigned BIT_SMON  = 4;
    localparam int unsigned BIT_SMOFF = 5;
    localparam int unsigned BIT_RST   = 7;
    localparam int unsigned BIT_STOP  = 8;

    localparam int unsigned NFLAG    = 2;
    localparam int unsigned FLAG_MST = 0;
    localparam int unsigned FLAG_SMB = 1;

    typedef struct packed {
        logic [NFLAG-1:0] set;
        logic [NFLAG-1:0] clr;
        logic             rst;
        logic             stop;
    } cmd_strobe_t;

    typedef struct packed {
        logic pend;
        logic hold;
        logic halt;
    } stop_state_t;

endpackage

// File: rtl/i2cm_cmd_decode.sv
module i2cm_cmd_decode
    import i2cm_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CMD_OFS = 0
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output cmd_strobe_t       strb
);

    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CMD_OFS);
    localparam logic [DATA_W-1:0] CMD_MASK =
        (DATA_W'(1) << BIT_MON)  | (DATA_W'(1) << BIT_MOFF) |
        (DATA_W'(1) << BIT_SMON) | (DATA_W'(1) << BIT_SMOFF) |
        (DATA_W'(1) << BIT_RST)  | (DATA_W'(1) << BIT_STOP);

    logic hit;
    logic unused_rsvd;

    always_comb begin
        hit  = bus_wr && (bus_addr == OFS);
        strb = '0;
        strb.set[FLAG_MST] = hit && bus_wdata[BIT_MON];
        strb.clr[FLAG_MST] = hit && bus_wdata[BIT_MOFF];
        strb.set[FLAG_SMB] = hit && bus_wdata[BIT_SMON];
        strb.clr[FLAG_SMB] = hit && bus_wdata[BIT_SMOFF];
        strb.rst           = hit && bus_wdata[BIT_RST];
        strb.stop          = hit && bus_wdata[BIT_STOP];
        unused_rsvd        = ^(bus_wdata & ~CMD_MASK);
    end

endmodule

// File: rtl/i2cm_mode_flag.sv
module i2cm_mode_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set) flag_d = 1'b1;
        if (clr) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign q = flag_q;

endmodule

// File: rtl/i2cm_stop_ctrl.sv
module i2cm_stop_ctrl
    import i2cm_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_cmd,
    input  logic stop_cmd,
    input  logic resume_cmd,
    input  logic xfer_active,
    input  logic shf_idle,
    input  logic stop_done,
    output logic stop_req,
    output logic xfer_hold,
    output logic halt
);

    stop_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.halt = 1'b0;
        if (halt_cmd) begin
            st_d.pend = 1'b0;
            st_d.hold = 1'b0;
            st_d.halt = 1'b1;
        end else begin
            if (st_q.pend && stop_done) begin
                st_d.pend = 1'b0;
                st_d.hold = 1'b1;
            end else begin
                if (stop_cmd && xfer_active) st_d.pend = 1'b1;
                if (resume_cmd)              st_d.hold = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stop_req  = st_q.pend && shf_idle;
    assign xfer_hold = st_q.hold;
    assign halt      = st_q.halt;

endmodule

// File: rtl/i2cm_cmd_reg.sv
module i2cm_cmd_reg
    import i2cm_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CMD_OFS = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              shf_idle,
    input  logic              xfer_active,
    input  logic              stop_done,
    output logic              master_on,
    output logic              smbus_on,
    output logic              stop_req,
    output logic              halt,
    output logic              xfer_hold
);

    cmd_strobe_t      strb;
    logic [NFLAG-1:0] flags;

    i2cm_cmd_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CMD_OFS(CMD_OFS)
    ) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .strb     (strb)
    );

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        i2cm_mode_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (strb.set[g]),
            .clr  (strb.clr[g]),
            .q    (flags[g])
        );
    end

    i2cm_stop_ctrl u_stop (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_cmd   (strb.rst && flags[FLAG_MST]),
        .stop_cmd   (strb.stop),
        .resume_cmd (strb.set[FLAG_MST]),
        .xfer_active(xfer_active),
        .shf_idle   (shf_idle),
        .stop_done  (stop_done),
        .stop_req   (stop_req),
        .xfer_hold  (xfer_hold),
        .halt       (halt)
    );

    assign master_on = flags[FLAG_MST];
    assign smbus_on  = flags[FLAG_SMB];
    assign bus_rdata = '0;

endmodule

// File: rtl/i2cm_cmd_reg_chk.sv
module i2cm_cmd_reg_chk #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CMD_OFS = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              shf_idle,
    input logic              stop_done,
    input logic              master_on,
    input logic              smbus_on,
    input logic              stop_req,
    input logic              halt,
    input logic              xfer_hold
);

    // R2
    mdis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(CMD_OFS) && bus_wdata[1]) |=> !master_on);

    // R3
    smdis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(CMD_OFS) && bus_wdata[5]) |=> !smbus_on);

    // R4
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(master_on) && $stable(smbus_on)));

    // R5
    halt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !halt);

    // R5
    halt_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> $past(master_on));

    // R6
    halt_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!stop_req && !xfer_hold));

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> shf_idle);

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && stop_done) |=> !stop_req);

    // R10
    hold_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && stop_done) |=> xfer_hold);

    // R11
    rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata == '0);

endmodule

bind i2cm_cmd_reg i2cm_cmd_reg_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CMD_OFS(CMD_OFS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .shf_idle (shf_idle),
    .stop_done(stop_done),
    .master_on(master_on),
    .smbus_on (smbus_on),
    .stop_req (stop_req),
    .halt     (halt),
    .xfer_hold(xfer_hold)
);

// File: tb/i2cm_cmd_reg_test.sv
module i2cm_cmd_reg_test;

    localparam int unsigned AW = 8;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          shf_idle = 1'b0;
    logic          xfer_active = 1'b0;
    logic          stop_done = 1'b0;
    logic          master_on, smbus_on, stop_req, halt, xfer_hold;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    i2cm_cmd_reg #(.ADDR_W(AW), .DATA_W(DW), .CMD_OFS(0)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .shf_idle(shf_idle),
        .xfer_active(xfer_active), .stop_done(stop_done),
        .master_on(master_on), .smbus_on(smbus_on), .stop_req(stop_req),
        .halt(halt), .xfer_hold(xfer_hold)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; bus_addr = '0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        stop_done = 1'b1;
        @(negedge clk);
        stop_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 master_on", master_on, 0);
        chk("R1 smbus_on", smbus_on, 0);
        chk("R1 stop_req", stop_req, 0);
        chk("R1 halt", halt, 0);
        chk("R1 xfer_hold", xfer_hold, 0);
        chk("R11 rdata", bus_rdata, 0);
    endtask

    task automatic t_master();
        wr(0, 32'h1);
        chk("R2 set", master_on, 1);
        wr(0, 32'h2);
        chk("R2 clear", master_on, 0);
        wr(0, 32'h1);
        wr(0, 32'h3);
        chk("R2 both", master_on, 0);
        wr(0, 32'h1);
        chk("R2 reset", master_on, 1);
    endtask

    task automatic t_smbus();
        wr(0, 32'h10);
        chk("R3 set", smbus_on, 1);
        chk("R3 master kept", master_on, 1);
        wr(0, 32'h20);
        chk("R3 clear", smbus_on, 0);
        wr(0, 32'h10);
        wr(0, 32'h30);
        chk("R3 both", smbus_on, 0);
        wr(0, 32'h10);
    endtask

    task automatic t_noeffect();
        wr(0, 32'h0);
        chk("R4 zero write master", master_on, 1);
        chk("R4 zero write smbus", smbus_on, 1);
        wr(0, 32'hFFFF_FE4C);
        chk("R4 reserved master", master_on, 1);
        chk("R4 reserved smbus", smbus_on, 1);
        chk("R4 reserved halt", halt, 0);
        wr(8'h04, 32'h0000_01A2);
        chk("R4 other offset master", master_on, 1);
        chk("R4 other offset smbus", smbus_on, 1);
        chk("R4 other offset halt", halt, 0);
        chk("R11 rdata", bus_rdata, 0);
    endtask

    task automatic t_stop();
        xfer_active = 1'b1; shf_idle = 1'b0;
        wr(0, 32'h100);
        chk("R8 wait busy", stop_req, 0);
        wr(0, 32'h100);
        @(negedge clk); shf_idle = 1'b1; #1;
        chk("R8 issue idle", stop_req, 1);
        chk("R7 pend", stop_req, 1);
        done_pulse();
        chk("R9 cleared", stop_req, 0);
        chk("R10 hold set", xfer_hold, 1);
        @(negedge clk);
        chk("R9 absorbed second", stop_req, 0);
        wr(0, 32'h10);
        chk("R10 hold kept", xfer_hold, 1);
        wr(0, 32'h1);
        chk("R10 hold resumed", xfer_hold, 0);
        xfer_active = 1'b0;
        wr(0, 32'h100);
        chk("R7 ignored inactive", stop_req, 0);
    endtask

    task automatic t_halt();
        xfer_active = 1'b1; shf_idle = 1'b0;
        wr(0, 32'h100);
        @(negedge clk); shf_idle = 1'b1; #1;
        chk("R7 pend again", stop_req, 1);
        @(negedge clk); shf_idle = 1'b0;
        wr(0, 32'h80);
        chk("R5 pulse", halt, 1);
        chk("R6 master kept", master_on, 1);
        chk("R6 smbus kept", smbus_on, 1);
        @(negedge clk);
        chk("R5 one cycle", halt, 0);
        shf_idle = 1'b1; #1;
        chk("R6 pend cleared", stop_req, 0);
        xfer_active = 1'b0;
        wr(0, 32'h2);
        wr(0, 32'h80);
        chk("R5 off ignored", halt, 0);
        wr(0, 32'h81);
        chk("R5 same write enable", halt, 0);
        chk("R2 enabled", master_on, 1);
        @(negedge clk);
        chk("R5 no late pulse", halt, 0);
        chk("R11 rdata", bus_rdata, 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_master();
        t_smbus();
        t_noeffect();
        t_stop();
        t_halt();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule